// File: doc/BRIEF.md
# UART Bit-Rate Generator and Transmit Framer

This block produces the bit-period tick of a serial transmitter and shifts bytes out on a single line in a programmable asynchronous frame. The bit rate comes from two cascaded counters. The first divides the selected clock by a 16-bit clock divisor. The second divides that result by an 8-bit bit divisor plus one. An optional fixed prescale by eight can sit in front of both. The selected clock is either the block clock or that clock divided by eight.

Three write strobes share one configuration data bus. They load the clock divisor, the bit divisor and the mode byte. Divisor writes with out-of-range values are dropped. The mode byte selects the prescale, the data length, the parity and the stop-bit count.

Bytes arrive on a ready/valid input. Once a byte is accepted, the framer waits for the next bit tick. It then drives the start bit, the data bits least significant bit first, an optional parity bit and the stop bits, with each bit held for exactly one bit period.

The transmit state machine has six states:
- IDLE: the line is high and `in_ready` is high.
- ALIGN: entered from IDLE on a handshake; it waits for a tick.
- START: entered from ALIGN on a tick; it drives the start bit.
- DATA: entered from START on a tick; it steps through the data bits on ticks.
- PARITY: entered from DATA after the last data bit when parity is on.
- STOP: entered from DATA or PARITY. It stays for a second tick when two stop bits are selected, then returns to IDLE.

Top module: `uart_baud_tx`

## Requirements
- R1: With mode bit 0 clear, `baud_tick` pulses once every clock-divisor × (bit-divisor + 1) clock cycles.
- R2: With mode bit 0 set, the tick period is 8 × clock-divisor × (bit-divisor + 1) clock cycles.
- R3: A clock-divisor write stores the low 16 bits of `cfg_wdata`, and a write whose full value is zero is ignored. A stored zero divides by 65536.
- R4: A bit-divisor write stores the low 8 bits of `cfg_wdata`, and a write whose full value is below 4 is ignored.
- R5: After reset the clock divisor is 0x28B, the bit divisor is 0x0F and the mode byte is 0. This gives a 10416-cycle tick period, with `txd` high and `in_ready` high.
- R6: Mode bits [2:1] choose the data length: 3 gives 6 bits, 2 gives 7 bits, and 0 or 1 gives 8 bits. Only that many low bits of the byte are sent.
- R7: Mode bits [5:3] choose the parity: 0 is even, 1 is odd, and 2 to 7 send no parity bit. Even parity sends the XOR of the sent data bits, and odd parity sends its inverse.
- R8: Mode bits [7:6] choose the stop bits: 3 gives one stop bit, and any other value gives two.
- R9: The line idles high. A frame is a low start bit, then the data least significant bit first, then parity if enabled, then high stop bits.
- R10: `in_ready` is high only in IDLE. The start bit begins the cycle after the first tick that follows acceptance, and every bit lasts one tick period.
- R11: The frame format is captured when a byte is accepted, so a mode write during a frame does not change that frame.
- R12: An accepted divisor write, or a mode write that changes bit 0, restarts the counters. The first tick then comes exactly one full period after the cycle following the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clkdiv_we | input | 1 | Clock-divisor write strobe |
| bitdiv_we | input | 1 | Bit-divisor write strobe |
| mode_we | input | 1 | Mode byte write strobe |
| cfg_wdata | input | 32 | Shared configuration write data |
| in_valid | input | 1 | Byte to send is offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Framer is idle and takes a byte |
| txd | output | 1 | Serial line |
| baud_tick | output | 1 | One-cycle pulse per bit period |

## Verification
The tick period is measured under three settings:
- The reset divisors, which check the reset state of both registers.
- A small divisor pair, which checks the product formula.
- The same pair with the prescale on, which isolates the factor of eight.

Rejected and wrapped divisor writes are checked through the period that follows them. Wide values show that truncation is distinct from rejection. The delay from a write to the first tick shows that the counters restart.

Frames are sampled at mid-bit under three formats:
- 8 bits, even parity, two stop bits.
- 7 bits, odd parity, one stop bit.
- 6 bits, no parity.

The byte values are chosen so that a wrong bit order, parity sense, length or stop count gives a different bit vector. A mode write during a frame checks that the format was captured at acceptance.

// File: rtl/uart_baud_tx_pkg.sv
package uart_baud_tx_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = 4;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ALIGN,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] nbits;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
    } frame_fmt_t;

    function automatic frame_fmt_t decode_fmt(input logic [7:0] mode);
        frame_fmt_t f;
        unique case (mode[2:1])
            2'd3:    f.nbits = 4'd6;
            2'd2:    f.nbits = 4'd7;
            default: f.nbits = 4'd8;
        endcase
        f.par_en   = (mode[5:3] == 3'd0) || (mode[5:3] == 3'd1);
        f.par_odd  = (mode[5:3] == 3'd1);
        f.two_stop = (mode[7:6] != 2'd3);
        return f;
    endfunction

endpackage

// File: rtl/uart_div_regs.sv
module uart_div_regs #(
    parameter int unsigned CFG_W      = 32,
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned BDIV_W     = 8,
    parameter int unsigned MIN_BDIV   = 4,
    parameter int unsigned RST_CLKDIV = 16'h028B,
    parameter int unsigned RST_BITDIV = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clkdiv_we,
    input  logic              bitdiv_we,
    input  logic              mode_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [DIV_W-1:0]  clk_div,
    output logic [BDIV_W-1:0] bit_div,
    output logic [7:0]        mode,
    output logic              reload
);

    logic clk_ok;
    logic bit_ok;
    logic sel_flip;

    // Rejection looks at the whole written value, not the kept slice.
    assign clk_ok   = clkdiv_we && (cfg_wdata != '0);
    assign bit_ok   = bitdiv_we && (cfg_wdata >= CFG_W'(MIN_BDIV));
    assign sel_flip = mode_we && (cfg_wdata[0] != mode[0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_div <= DIV_W'(RST_CLKDIV);
            bit_div <= BDIV_W'(RST_BITDIV);
            mode    <= '0;
            reload  <= 1'b0;
        end else begin
            if (clk_ok) clk_div <= cfg_wdata[DIV_W-1:0];
            if (bit_ok) bit_div <= cfg_wdata[BDIV_W-1:0];
            if (mode_we) mode   <= cfg_wdata[7:0];
            reload <= clk_ok || bit_ok || sel_flip;
        end
    end

endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned BDIV_W   = 8,
    parameter int unsigned PRESCALE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              pre_sel,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [BDIV_W-1:0] bit_div,
    output logic              bit_tick
);

    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic              pre_en;
    logic              samp;
    logic [DIV_W-1:0]  clk_cnt;
    logic [DIV_W-1:0]  clk_last;
    logic [BDIV_W-1:0] bit_cnt;

    generate
        if (PRESCALE > 1) begin : g_pre
            logic [PRE_W-1:0] pre_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       pre_cnt <= '0;
                else if (reload)  pre_cnt <= '0;
                else if (pre_sel) pre_cnt <= (pre_cnt == PRE_W'(PRESCALE - 1)) ? '0 : pre_cnt + 1'b1;
            end
            assign pre_en = !pre_sel || (pre_cnt == PRE_W'(PRESCALE - 1));
        end else begin : g_nopre
            assign pre_en = 1'b1;
        end
    endgenerate

    // A stored zero wraps to all ones here, giving the full 2^DIV_W span.
    assign clk_last = clk_div - {{(DIV_W-1){1'b0}}, 1'b1};
    assign samp     = !reload && pre_en && (clk_cnt == clk_last);
    assign bit_tick = samp && (bit_cnt == bit_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_cnt <= '0;
            bit_cnt <= '0;
        end else if (reload) begin
            clk_cnt <= '0;
            bit_cnt <= '0;
        end else begin
            if (pre_en) clk_cnt <= samp ? '0 : clk_cnt + 1'b1;
            if (samp)   bit_cnt <= bit_tick ? '0 : bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_baud_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  frame_fmt_t        fmt_in,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd
);

    tx_state_e         state_q, state_d;
    frame_fmt_t        fmt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              par_q;
    logic              accept;
    logic [BYTE_W-1:0] mask;
    logic [CNT_W-1:0]  last_bit;

    assign in_ready = (state_q == TX_IDLE);
    assign accept   = in_ready && in_valid;
    assign mask     = {BYTE_W{1'b1}} >> (CNT_W'(BYTE_W) - fmt_in.nbits);
    assign last_bit = fmt_q.nbits - 4'd1;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (in_valid) state_d = TX_ALIGN;
            TX_ALIGN:  if (bit_tick) state_d = TX_START;
            TX_START:  if (bit_tick) state_d = TX_DATA;
            TX_DATA:
                if (bit_tick && cnt_q == last_bit)
                    state_d = fmt_q.par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_tick) state_d = TX_STOP;
            TX_STOP:
                if (bit_tick && !(fmt_q.two_stop && cnt_q == '0))
                    state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q <= '0;
            sh_q  <= '0;
            cnt_q <= '0;
            par_q <= 1'b0;
        end else begin
            if (accept) begin
                fmt_q <= fmt_in;
                sh_q  <= in_data & mask;
                par_q <= (^(in_data & mask)) ^ fmt_in.par_odd;
                cnt_q <= '0;
            end else if (bit_tick) begin
                unique case (state_q)
                    TX_DATA: begin
                        sh_q  <= sh_q >> 1;
                        cnt_q <= (cnt_q == last_bit) ? '0 : cnt_q + 1'b1;
                    end
                    TX_STOP: cnt_q <= cnt_q + 1'b1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    // Line output
    always_comb begin
        unique case (state_q)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = sh_q[0];
            TX_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_baud_tx.sv
module uart_baud_tx
    import uart_baud_tx_pkg::*;
#(
    parameter int unsigned CFG_W      = 32,
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned BDIV_W     = 8,
    parameter int unsigned MIN_BDIV   = 4,
    parameter int unsigned PRESCALE   = 8,
    parameter int unsigned RST_CLKDIV = 16'h028B,
    parameter int unsigned RST_BITDIV = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clkdiv_we,
    input  logic             bitdiv_we,
    input  logic             mode_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             txd,
    output logic             baud_tick
);

    logic [DIV_W-1:0]  clk_div_w;
    logic [BDIV_W-1:0] bit_div_w;
    logic [7:0]        mode_w;
    logic              reload_w;
    frame_fmt_t        fmt_w;

    assign fmt_w = decode_fmt(mode_w);

    uart_div_regs #(
        .CFG_W(CFG_W), .DIV_W(DIV_W), .BDIV_W(BDIV_W), .MIN_BDIV(MIN_BDIV),
        .RST_CLKDIV(RST_CLKDIV), .RST_BITDIV(RST_BITDIV)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .clkdiv_we(clkdiv_we), .bitdiv_we(bitdiv_we), .mode_we(mode_we),
        .cfg_wdata(cfg_wdata),
        .clk_div(clk_div_w), .bit_div(bit_div_w), .mode(mode_w), .reload(reload_w)
    );

    uart_tick_gen #(
        .DIV_W(DIV_W), .BDIV_W(BDIV_W), .PRESCALE(PRESCALE)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .reload(reload_w), .pre_sel(mode_w[0]),
        .clk_div(clk_div_w), .bit_div(bit_div_w), .bit_tick(baud_tick)
    );

    uart_tx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_tick(baud_tick), .fmt_in(fmt_w),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd)
    );

endmodule

// File: rtl/uart_baud_tx_chk.sv
module uart_baud_tx_chk #(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned BDIV_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_tick,
    input logic              txd,
    input logic              in_valid,
    input logic              in_ready,
    input logic              reload,
    input logic [DIV_W-1:0]  clk_div,
    input logic [BDIV_W-1:0] bit_div
);

    // R9: line is high whenever the framer is idle
    assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> txd);

    // R9: line never unknown
    assert_txd_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(txd));

    // R10: the line only moves right after a bit tick
    assert_line_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(baud_tick));

    // R10: a handshake takes the framer out of idle
    assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R12: after a restart no tick comes in the next cycle unless the period is one
    assert_restart_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reload) && !(clk_div == DIV_W'(1) && bit_div == '0)) |-> !baud_tick);

endmodule

bind uart_baud_tx uart_baud_tx_chk #(.DIV_W(DIV_W), .BDIV_W(BDIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .txd(txd),
    .in_valid(in_valid), .in_ready(in_ready), .reload(reload_w),
    .clk_div(clk_div_w), .bit_div(bit_div_w)
);

// File: tb/tb_uart_baud_tx.sv
module tb_uart_baud_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clkdiv_we = 1'b0;
    logic        bitdiv_we = 1'b0;
    logic        mode_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        txd;
    logic        baud_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    uart_baud_tx dut (
        .clk(clk), .rst_n(rst_n), .clkdiv_we(clkdiv_we), .bitdiv_we(bitdiv_we),
        .mode_we(mode_we), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .txd(txd), .baud_tick(baud_tick)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] val);
        @(negedge clk);
        cfg_wdata = val;
        clkdiv_we = (sel == 0);
        bitdiv_we = (sel == 1);
        mode_we   = (sel == 2);
        @(negedge clk);
        clkdiv_we = 1'b0; bitdiv_we = 1'b0; mode_we = 1'b0;
    endtask

    task automatic measure(output int p);
        int n = 0;
        @(negedge clk);
        while (!baud_tick && n < 40000) begin @(negedge clk); n++; end
        p = 0;
        @(negedge clk); p = 1;
        while (!baud_tick && p < 40000) begin @(negedge clk); p++; end
    endtask

    task automatic t_reset;
        int p;
        check("R5 txd idle", txd, 1);
        check("R5 ready", in_ready, 1);
        measure(p);
        check("R5 period", p, 651 * 16);
    endtask

    task automatic t_period;
        int p;
        wr(0, 3); wr(1, 4);
        measure(p);
        check("R1 period 3x5", p, 15);
    endtask

    // write then count negedges until the first tick
    task automatic t_restart(input int sel, input logic [31:0] val, input int per, input string req);
        int n;
        @(negedge clk);
        cfg_wdata = val;
        clkdiv_we = (sel == 0); bitdiv_we = (sel == 1); mode_we = (sel == 2);
        @(negedge clk);
        clkdiv_we = 1'b0; bitdiv_we = 1'b0; mode_we = 1'b0;
        n = 1;
        while (!baud_tick && n < 2000) begin @(negedge clk); n++; end
        check(req, n, per + 1);
    endtask

    task automatic t_prescale;
        int p;
        t_restart(2, 32'h1, 120, "R12 restart on select change");
        measure(p);
        check("R2 prescaled period", p, 120);
        wr(2, 32'h0);
        measure(p);
        check("R2 prescale off", p, 15);
    endtask

    task automatic t_clkdiv;
        int p;
        t_restart(0, 3, 15, "R12 restart on divisor write");
        wr(0, 0);
        measure(p);
        check("R3 zero write ignored", p, 15);
        wr(0, 32'h0001_0002);
        measure(p);
        check("R3 low 16 kept", p, 10);
        wr(0, 3);
    endtask

    task automatic t_bitdiv;
        int p;
        wr(1, 3);
        measure(p);
        check("R4 write 3 ignored", p, 15);
        wr(1, 0);
        measure(p);
        check("R4 write 0 ignored", p, 15);
        wr(1, 32'h105);
        measure(p);
        check("R4 low 8 kept", p, 18);
        wr(1, 4);
        measure(p);
        check("R4 write 4 taken", p, 15);
    endtask

    // Send one byte and sample the frame at mid-bit (period 15)
    task automatic t_frame(input logic [7:0] mode, input logic [7:0] b,
                           input bit change_mode, input string req);
        int nb, n, nbit;
        bit pen, podd, two;
        bit exp_bits[16];
        bit par;
        nb   = (mode[2:1] == 2'd3) ? 6 : (mode[2:1] == 2'd2) ? 7 : 8;
        pen  = (mode[5:3] <= 3'd1);
        podd = (mode[5:3] == 3'd1);
        two  = (mode[7:6] != 2'd3);
        nbit = 0;
        exp_bits[nbit++] = 1'b0;
        par = podd;
        for (int i = 0; i < nb; i++) begin
            exp_bits[nbit++] = b[i];
            par ^= b[i];
        end
        if (pen) exp_bits[nbit++] = par;
        exp_bits[nbit++] = 1'b1;
        if (two) exp_bits[nbit++] = 1'b1;
        exp_bits[nbit++] = 1'b1;  // line back to idle
        wr(2, {24'h0, mode});
        @(negedge clk);
        in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (change_mode) wr(2, 32'hCC);
        n = 0;
        while (txd && n < 100) begin @(negedge clk); n++; end
        for (int k = 0; k < 7; k++) @(negedge clk);
        check({req, " R10 busy"}, in_ready, 0);
        for (int i = 0; i < nbit; i++) begin
            check($sformatf("%s R9 bit %0d", req, i), txd, exp_bits[i]);
            for (int k = 0; k < 15; k++) @(negedge clk);
        end
        n = 0;
        while (!in_ready && n < 100) begin @(negedge clk); n++; end
        check({req, " R10 ready again"}, in_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_period;
        t_clkdiv;
        t_prescale;
        t_bitdiv;
        t_frame(8'h00, 8'hA5, 0, "R6 R7 R8 8E2");
        t_frame(8'hCC, 8'h53, 0, "R6 R7 R8 7O1");
        t_frame(8'h26, 8'hFF, 0, "R6 R7 6N2");
        t_frame(8'h00, 8'h3C, 1, "R11 captured format");
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule